// File: doc/BRIEF.md
# Floating-Point Min/Max Selector

This block picks one of two floating-point operands and returns it unchanged. An operation code chooses one of four selections. Signed maximum and signed minimum compare the true values. Magnitude maximum and magnitude minimum compare absolute values and ignore the signs. Operands use a wide register layout: a sign bit, an exponent field and a significand with an explicit integer bit. The chosen operand is copied bit for bit, so no rounding takes place.

Each request comes with a 2-bit status-field selector. When either operand is a NaN, the block returns the second operand and raises an invalid flag. The flag is placed in a one-hot vector at the position of the selected field, so a status unit downstream can record it against the right field. A request is taken when its valid strobe is high. The result is registered and appears one cycle later with a one-cycle output-valid pulse.

Top module: `fmm_select`

## Requirements
- R1: Operation code 2'b00 returns the larger of the two operands by signed value, and code 2'b01 returns the smaller.
- R2: Operation code 2'b10 returns the operand with the larger absolute value, and code 2'b11 returns the one with the smaller absolute value. The sign bits play no part in these comparisons.
- R3: When the operands are equal, the result is always the second operand (b), bit for bit. Equal means equal by value for codes 00/01 and equal by magnitude for codes 10/11. +0 and -0 count as equal.
- R4: Magnitudes are ordered first by the unsigned exponent and then by the unsigned significand. An operand whose significand is all zeros, with an exponent that is not all ones, is a zero, and it ranks below every non-zero operand whatever its exponent field holds.
- R5: A request accepted on a rising edge with in_valid high appears on res in the same edge's register update. out_valid is high for exactly that one cycle. res holds an exact copy of the selected operand's {sign, exponent, significand} bits.
- R6: An operand is a NaN when its exponent is all ones and significand bits [SIG_W-2:0] are not all zero. If either operand is a NaN, the result is the second operand and invalid is 1. An infinity (exponent all ones, those bits zero) is not a NaN and ranks above all finite values.
- R7: inv_field is one-hot at bit position sf when invalid is 1, and all zeros otherwise. Selector value 0 is the default field.
- R8: While in_valid is low, out_valid is 0, invalid is 0, inv_field is 0, and res keeps its last value even when the operands change.
- R9: After reset, res, out_valid, invalid and inv_field are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation code (00 max, 01 min, 10 magnitude max, 11 magnitude min) |
| sf | input | 2 | Status-field selector |
| opnd_a | input | 1+EXP_W+SIG_W | First operand {sign, exponent, significand} |
| opnd_b | input | 1+EXP_W+SIG_W | Second operand {sign, exponent, significand} |
| out_valid | output | 1 | One-cycle result strobe |
| res | output | 1+EXP_W+SIG_W | Selected operand, copied unchanged |
| invalid | output | 1 | NaN operand seen |
| inv_field | output | 4 | One-hot field tag for the invalid flag |

## Verification
Two rules can claim the same request: the tie rule and the NaN rule both send the second operand to the output. Requests where b is a NaN and a is ordinary, where a is a NaN, and where the operands tie without any NaN are each given in turn. The check is that invalid and inv_field rise only for the NaN cases, even though res is b in all of them. In the same way, signed ties between +0 and -0 are driven with both operand orders, so that the sign of the returned zero shows which rule decided the result.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    typedef enum logic [1:0] {
        OP_SMAX = 2'b00,
        OP_SMIN = 2'b01,
        OP_AMAX = 2'b10,
        OP_AMIN = 2'b11
    } fmm_op_e;

    localparam int NUM_FIELDS = 4;

endpackage

// File: rtl/fmm_class.sv
module fmm_class #(
    parameter int EXP_W = 17,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic             is_nan,
    output logic             is_zero
);
    logic exp_max;
    logic frac_nz;

    always_comb begin
        exp_max = &exp_i;
        frac_nz = |sig_i[SIG_W-2:0];
        is_nan  = exp_max && frac_nz;
        is_zero = !exp_max && (sig_i == '0);
    end
endmodule

// File: rtl/fmm_mag_cmp.sv
module fmm_mag_cmp #(
    parameter int EXP_W = 17,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             a_zero,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    input  logic             b_zero,
    output logic             a_gt,
    output logic             a_lt
);
    always_comb begin
        a_gt = 1'b0;
        a_lt = 1'b0;
        if (a_zero && b_zero) begin
            a_gt = 1'b0;
            a_lt = 1'b0;
        end else if (a_zero) begin
            a_lt = 1'b1;
        end else if (b_zero) begin
            a_gt = 1'b1;
        end else if (a_exp != b_exp) begin
            a_gt = a_exp > b_exp;
            a_lt = a_exp < b_exp;
        end else begin
            a_gt = a_sig > b_sig;
            a_lt = a_sig < b_sig;
        end
    end

    always_comb begin
        assert (!(a_gt && a_lt)) else $error("a_r4_order_exclusive");
    end
endmodule

// File: rtl/fmm_select.sv
module fmm_select
    import fmm_pkg::*;
#(
    parameter int EXP_W = 17,
    parameter int SIG_W = 64,
    localparam int OPND_W = 1 + EXP_W + SIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [1:0]        sf,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [OPND_W-1:0] res,
    output logic              invalid,
    output logic [NUM_FIELDS-1:0] inv_field
);
    typedef struct packed {
        logic                  vld;
        logic [OPND_W-1:0]     res;
        logic                  inv;
        logic [NUM_FIELDS-1:0] field;
    } state_t;

    state_t state_d, state_q;

    logic [1:0]       sgn;
    logic [EXP_W-1:0] ex [2];
    logic [SIG_W-1:0] sg [2];
    logic [1:0]       nan;
    logic [1:0]       zro;

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        logic [OPND_W-1:0] word;
        assign word  = (k == 0) ? opnd_a : opnd_b;
        assign sgn[k] = word[OPND_W-1];
        assign ex[k]  = word[SIG_W +: EXP_W];
        assign sg[k]  = word[SIG_W-1:0];
        fmm_class #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_class (
            .exp_i  (ex[k]),
            .sig_i  (sg[k]),
            .is_nan (nan[k]),
            .is_zero(zro[k])
        );
    end

    logic mag_gt, mag_lt;

    fmm_mag_cmp #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_mag (
        .a_exp (ex[0]),
        .a_sig (sg[0]),
        .a_zero(zro[0]),
        .b_exp (ex[1]),
        .b_sig (sg[1]),
        .b_zero(zro[1]),
        .a_gt  (mag_gt),
        .a_lt  (mag_lt)
    );

    logic    val_gt, val_lt, take_a, any_nan;
    fmm_op_e op_e;

    always_comb begin
        op_e    = fmm_op_e'(op);
        any_nan = |nan;
        if (zro[0] && zro[1]) begin
            val_gt = 1'b0;
            val_lt = 1'b0;
        end else if (sgn[0] != sgn[1]) begin
            val_gt = !sgn[0];
            val_lt = sgn[0];
        end else if (!sgn[0]) begin
            val_gt = mag_gt;
            val_lt = mag_lt;
        end else begin
            val_gt = mag_lt;
            val_lt = mag_gt;
        end
        unique case (op_e)
            OP_SMAX: take_a = val_gt;
            OP_SMIN: take_a = val_lt;
            OP_AMAX: take_a = mag_gt;
            OP_AMIN: take_a = mag_lt;
            default: take_a = 1'b0;
        endcase
        if (any_nan) take_a = 1'b0;
    end

    always_comb begin
        state_d       = state_q;
        state_d.vld   = in_valid;
        state_d.inv   = 1'b0;
        state_d.field = '0;
        if (in_valid) begin
            state_d.res = take_a ? opnd_a : opnd_b;
            if (any_nan) begin
                state_d.inv   = 1'b1;
                state_d.field = NUM_FIELDS'(1) << sf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.vld;
    assign res       = state_q.res;
    assign invalid   = state_q.inv;
    assign inv_field = state_q.field;

    a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !invalid && $stable(res)));
    a_r5_copy: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res == $past(opnd_a) || res == $past(opnd_b)));
    a_r3_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opnd_a == opnd_b) |=> res == $past(opnd_b));
    a_r6_nan_second: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> res == $past(opnd_b));
    a_r7_field: assert property (@(posedge clk) disable iff (!rst_n)
        invalid ? ($countones(inv_field) == 1) : (inv_field == '0));
endmodule

// File: tb/test_fmm_select.sv
module test_fmm_select;
    localparam int EXP_W = 17;
    localparam int SIG_W = 64;
    localparam int W = 1 + EXP_W + SIG_W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op = '0;
    logic [1:0]   sf = '0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         out_valid;
    logic [W-1:0] res;
    logic         invalid;
    logic [3:0]   inv_field;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fmm_select #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_fmm_select (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sf(sf),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .res(res),
        .invalid(invalid), .inv_field(inv_field)
    );

    function automatic logic [W-1:0] mk(input logic s, input logic [EXP_W-1:0] e,
                                        input logic [SIG_W-1:0] m);
        return {s, e, m};
    endfunction

    localparam logic [EXP_W-1:0] BIAS = 17'h0FFFF;
    localparam logic [SIG_W-1:0] INT1 = 64'h8000_0000_0000_0000;
    localparam logic [SIG_W-1:0] ONE5 = 64'hC000_0000_0000_0000;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic run(input string req, input logic [1:0] o, input logic [1:0] f,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit want_b, input bit want_inv);
        logic [W-1:0] expv;
        expv = want_b ? b : a;
        @(negedge clk);
        op = o; sf = f; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R5 valid"}, W'(out_valid), W'(1));
        check({req, " result"}, res, expv);
        check({req, " R6 invalid"}, W'(invalid), W'(want_inv));
        check({req, " R7 field"}, W'(inv_field), want_inv ? W'(4'b1 << f) : W'(0));
    endtask

    task automatic t_reset();
        check("R9 res", res, '0);
        check("R9 valid", W'(out_valid), W'(0));
        check("R9 field", W'({invalid, inv_field}), W'(0));
    endtask

    task automatic t_signed();
        logic [W-1:0] p1, p2, n1, n2;
        p1 = mk(0, BIAS, INT1); p2 = mk(0, BIAS + 1, INT1);
        n1 = mk(1, BIAS, INT1); n2 = mk(1, BIAS + 1, INT1);
        run("R1 max(1,2)", 2'b00, 0, p1, p2, 1, 0);
        run("R1 max(2,1)", 2'b00, 0, p2, p1, 0, 0);
        run("R1 min(2,1)", 2'b01, 0, p2, p1, 1, 0);
        run("R1 max(-2,1)", 2'b00, 0, n2, p1, 1, 0);
        run("R1 min(-2,1)", 2'b01, 0, n2, p1, 0, 0);
        run("R1 max(-2,-1)", 2'b00, 0, n2, n1, 1, 0);
        run("R1 min(-2,-1)", 2'b01, 0, n2, n1, 0, 0);
    endtask

    task automatic t_magnitude();
        logic [W-1:0] p1, n2, p15, n15;
        p1 = mk(0, BIAS, INT1); n2 = mk(1, BIAS + 1, INT1);
        p15 = mk(0, BIAS, ONE5); n15 = mk(1, BIAS, ONE5);
        run("R2 amax(-2,1)", 2'b10, 0, n2, p1, 0, 0);
        run("R2 amin(-2,1)", 2'b11, 0, n2, p1, 1, 0);
        run("R4 amax(1,1.5)", 2'b10, 0, p1, p15, 1, 0);
        run("R4 amax(-1.5,1)", 2'b10, 0, n15, p1, 0, 0);
        run("R4 amin(-1.5,1)", 2'b11, 0, n15, p1, 1, 0);
        run("R4 zero below tiny", 2'b10, 0, mk(0, 17'd5, '0), mk(0, '0, 64'd1), 1, 0);
        run("R4 tiny over zero", 2'b11, 0, mk(0, '0, 64'd1), mk(0, 17'd5, '0), 1, 0);
    endtask

    task automatic t_ties();
        logic [W-1:0] pz, nz, p2, n2;
        pz = mk(0, '0, '0); nz = mk(1, '0, '0);
        p2 = mk(0, BIAS + 1, INT1); n2 = mk(1, BIAS + 1, INT1);
        run("R3 max(+0,-0)", 2'b00, 0, pz, nz, 1, 0);
        run("R3 min(-0,+0)", 2'b01, 0, nz, pz, 1, 0);
        run("R3 amax(-2,+2)", 2'b10, 0, n2, p2, 1, 0);
        run("R3 amin(+2,-2)", 2'b11, 0, p2, n2, 1, 0);
    endtask

    task automatic t_nan();
        logic [W-1:0] qn, inf, p1;
        qn = mk(0, '1, 64'hC000_0000_0000_0000);
        inf = mk(0, '1, INT1);
        p1 = mk(0, BIAS, INT1);
        run("R6 max(nan,1) sf2", 2'b00, 2'd2, qn, p1, 1, 1);
        run("R6 min(1,nan) sf3", 2'b01, 2'd3, p1, qn, 1, 1);
        run("R7 amax(nan,1) sf0", 2'b10, 2'd0, qn, p1, 1, 1);
        run("R6 max(inf,1)", 2'b00, 2'd1, inf, p1, 0, 0);
    endtask

    task automatic t_hold();
        logic [W-1:0] prev;
        prev = res;
        @(negedge clk);
        opnd_a = mk(1, 17'h1234, 64'hFFFF); opnd_b = mk(0, '1, 64'h1); sf = 2'd1;
        @(negedge clk);
        check("R8 hold res", res, prev);
        check("R8 idle valid", W'({out_valid, invalid, inv_field}), W'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_signed();
        t_magnitude();
        t_ties();
        t_nan();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule